// File: doc/BRIEF.md
# Byte-Sync Character Receiver

This block takes a serial bit stream for a byte-control link and turns it into characters. After the receiver is enabled, it searches for a programmable SYNC character one bit at a time. When the last N received bits match the pattern, it locks to that boundary. From then on it frames characters of a fixed length N, where N is selectable from 5 to 8 bits. Bits arrive least significant first. A bit is taken on each clock cycle in which `bit_en` is high.

Each framed character either goes to a one-entry output register or is dropped. Which one depends on the SYNC-stripping setting and on how far the link has progressed towards its first data character.

- With stripping on, no SYNC character is ever delivered. The first character that is not a SYNC is the first data character.
- With stripping off, the character that follows the second received SYNC is the first data character, even if it is itself a SYNC. Every character after it is delivered.

The output register is a valid/ready source:
- `out_valid` rises when a character is delivered.
- The character is taken by a cycle with `out_valid` and `out_ready` both high.
- Data stays stable while it waits.
- The line cannot be stalled. If a new character arrives while the previous one is still untaken, the new one replaces it and a sticky overrun flag is set.

`rx_active`, `sync_det` and `overrun` are plain status outputs. Pulling `rx_en` low clears everything, including alignment, so the next enable starts a fresh search.

Top module: `sync_char_rx`

## Requirements
- R1: While searching, on every `bit_en` cycle the block compares the last N received bits against the low N bits of `sync_pat`. The first received bit is the least significant. A match counts only once at least N bits have been received since `rx_en` rose. A match locks alignment.
- R2: `len_sel` values 0, 1, 2 and 3 select N = 5, 6, 7 and 8. Delivered data has zeros above bit N-1.
- R3: After lock, a character completes every N bits, counted from the bit that completed the SYNC.
- R4: With `strip_sync` = 1, SYNC characters are never delivered. The first non-SYNC character is delivered as the first data character.
- R5: With `strip_sync` = 0, characters before the second SYNC (including both SYNCs) are not delivered. The character after the second SYNC is delivered, even if it equals the SYNC, and so is every later character.
- R6: `sync_det` rises on the clock after a `bit_en` cycle that completes a SYNC match, either while searching or at a framed boundary. It holds until the clock after the next `bit_en` cycle.
- R7: `rx_active` rises together with `out_valid` for the first data character. It stays high until `rx_en` is low.
- R8: `out_valid` rises on the clock after a delivering `bit_en` cycle. It falls after a cycle with `out_ready` high, unless a new character is delivered in that same cycle, in which case it stays high with the new data. While `out_valid` is high and nothing is taken, `out_data` does not change.
- R9: If a character is delivered while `out_valid` is high and `out_ready` is low, `overrun` is set and the new character replaces the old one. `overrun` stays set until `rx_en` is low.
- R10: A clock with `rx_en` low clears `out_valid`, `rx_active`, `sync_det`, `overrun`, the received-bit history and alignment. The next enable restarts the search.
- R11: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable; low clears all receive state |
| bit_en | input | 1 | Marks the cycle that carries a new serial bit |
| rx_bit | input | 1 | Serial data bit |
| sync_pat | input | CHAR_W | SYNC pattern, low N bits used |
| len_sel | input | SEL_W | Character length select, N = 5 + len_sel |
| strip_sync | input | 1 | 1: drop all SYNC characters |
| out_data | output | CHAR_W | Delivered character, zero padded |
| out_valid | output | 1 | A character is waiting |
| out_ready | input | 1 | Consumer takes the waiting character |
| rx_active | output | 1 | First data character has been delivered |
| sync_det | output | 1 | SYNC seen, held for one bit time |
| overrun | output | 1 | A character was replaced before being taken |

## Verification
Four groups of patterns exercise the framing:

- **Table runs.** Each run covers one length with SYNC and non-SYNC characters in different orders. Stripped runs show that SYNCs are dropped wherever they appear. Unstripped runs separate the two counting rules: a non-SYNC before the second SYNC is dropped, while a SYNC right after it is delivered.
- **Bit-level search.** A search that starts with junk bits shows that a match is found at any bit offset and not earlier.
- **All-zero pattern.** A SYNC of all zeros shows that the fill guard blocks matches on partly filled history.
- **Output register and enable.** Directed steps cover overrun, a take in the same cycle as a new delivery, and loss of alignment after the enable is dropped.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_FRAMED = 1'b1
  } rxb_state_e;
endpackage

// File: rtl/rxb_shift.sv
module rxb_shift #(
  parameter int CHAR_W  = 8,
  parameter int MIN_LEN = 5,
  localparam int NLEN   = CHAR_W - MIN_LEN + 1,
  localparam int SEL_W  = (NLEN > 1) ? $clog2(NLEN) : 1,
  localparam int CNT_W  = $clog2(CHAR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              din,
  input  logic [SEL_W-1:0]  len_sel,
  input  logic [CNT_W-1:0]  len_val,
  output logic [CHAR_W-1:0] win,
  output logic              full
);
  logic [CHAR_W-1:0] hist_q, hist_nx;
  logic [CNT_W-1:0]  fill_q, fill_nx;
  logic [CHAR_W-1:0] cand [NLEN];

  // newest bit at the top; window of the last N bits includes the current one
  assign hist_nx = {din, hist_q[CHAR_W-1:1]};
  assign fill_nx = (fill_q == CNT_W'(CHAR_W)) ? fill_q : fill_q + 1'b1;

  for (genvar g = 0; g < NLEN; g++) begin : g_len
    assign cand[g] = CHAR_W'(hist_nx[CHAR_W-1 : CHAR_W-MIN_LEN-g]);
  end

  always_comb begin
    win = cand[NLEN-1];
    for (int i = 0; i < NLEN; i++) begin
      if (len_sel == SEL_W'(i)) win = cand[i];
    end
  end

  assign full = (fill_nx >= len_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (clr) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (shift_en) begin
      hist_q <= hist_nx;
      fill_q <= fill_nx;
    end
  end
endmodule

// File: rtl/rxb_frame.sv
module rxb_frame
  import rxb_pkg::*;
#(
  parameter int CHAR_W  = 8,
  localparam int CNT_W  = $clog2(CHAR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              bit_en,
  input  logic [CHAR_W-1:0] win,
  input  logic              full,
  input  logic [CNT_W-1:0]  len_val,
  input  logic [CHAR_W-1:0] sync_pat,
  input  logic              strip_sync,
  output logic              deliver,
  output logic [CHAR_W-1:0] char_data,
  output logic              sync_det,
  output logic              rx_active
);
  rxb_state_e       state_q;
  logic [CNT_W-1:0] bcnt_q;
  logic             second_q;
  logic [CHAR_W-1:0] pat_m;
  logic             is_sync, boundary;

  always_comb begin
    for (int i = 0; i < CHAR_W; i++) begin
      pat_m[i] = (CNT_W'(i) < len_val) ? sync_pat[i] : 1'b0;
    end
  end

  assign is_sync   = (win == pat_m);
  assign boundary  = (state_q == ST_FRAMED) && (bcnt_q + 1'b1 == len_val);
  assign char_data = win;

  always_comb begin
    deliver = 1'b0;
    if (bit_en && boundary) begin
      if (strip_sync)     deliver = !is_sync;
      else if (rx_active) deliver = 1'b1;
      else                deliver = second_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_SEARCH;
      bcnt_q    <= '0;
      second_q  <= 1'b0;
      sync_det  <= 1'b0;
      rx_active <= 1'b0;
    end else if (clr) begin
      state_q   <= ST_SEARCH;
      bcnt_q    <= '0;
      second_q  <= 1'b0;
      sync_det  <= 1'b0;
      rx_active <= 1'b0;
    end else if (bit_en) begin
      if (state_q == ST_SEARCH) begin
        sync_det <= full && is_sync;
        if (full && is_sync) begin
          state_q <= ST_FRAMED;
          bcnt_q  <= '0;
        end
      end else if (boundary) begin
        bcnt_q   <= '0;
        sync_det <= is_sync;
        if (is_sync) second_q <= 1'b1;
        if (deliver) rx_active <= 1'b1;
      end else begin
        bcnt_q   <= bcnt_q + 1'b1;
        sync_det <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rxb_hold.sv
module rxb_hold #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [CHAR_W-1:0] push_data,
  input  logic              pop,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_valid,
  output logic              overrun
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      overrun   <= 1'b0;
    end else if (clr) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (push) begin
        out_data  <= push_data;
        out_valid <= 1'b1;
        if (out_valid && !pop) overrun <= 1'b1;
      end else if (pop) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sync_char_rx.sv
module sync_char_rx #(
  parameter int CHAR_W  = 8,
  parameter int MIN_LEN = 5,
  localparam int NLEN   = CHAR_W - MIN_LEN + 1,
  localparam int SEL_W  = (NLEN > 1) ? $clog2(NLEN) : 1,
  localparam int CNT_W  = $clog2(CHAR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              bit_en,
  input  logic              rx_bit,
  input  logic [CHAR_W-1:0] sync_pat,
  input  logic [SEL_W-1:0]  len_sel,
  input  logic              strip_sync,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              rx_active,
  output logic              sync_det,
  output logic              overrun
);
  logic              clr;
  logic [CNT_W-1:0]  len_val;
  logic [CHAR_W-1:0] win, char_data;
  logic              full, deliver;

  assign clr = !rx_en;

  always_comb begin
    len_val = CNT_W'(CHAR_W);
    for (int i = 0; i < NLEN; i++) begin
      if (len_sel == SEL_W'(i)) len_val = CNT_W'(MIN_LEN + i);
    end
  end

  rxb_shift #(.CHAR_W(CHAR_W), .MIN_LEN(MIN_LEN)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .shift_en (bit_en),
    .din      (rx_bit),
    .len_sel  (len_sel),
    .len_val  (len_val),
    .win      (win),
    .full     (full)
  );

  rxb_frame #(.CHAR_W(CHAR_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .bit_en     (bit_en),
    .win        (win),
    .full       (full),
    .len_val    (len_val),
    .sync_pat   (sync_pat),
    .strip_sync (strip_sync),
    .deliver    (deliver),
    .char_data  (char_data),
    .sync_det   (sync_det),
    .rx_active  (rx_active)
  );

  rxb_hold #(.CHAR_W(CHAR_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .push      (deliver),
    .push_data (char_data),
    .pop       (out_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .overrun   (overrun)
  );
endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              bit_en,
  input logic [CHAR_W-1:0] out_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic              rx_active,
  input logic              sync_det,
  input logic              overrun
);
  // R7: once active, stays active while enabled
  p_active_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_active && rx_en) |=> rx_active);

  // R10: a disabled cycle clears status
  p_disable_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rx_active && !out_valid && !overrun && !sync_det));

  // R8: waiting character is not lost
  p_valid_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && rx_en) |=> out_valid);

  // R8: data stable while waiting and no new bit
  p_data_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && rx_en && !bit_en) |=> $stable(out_data));

  // R9: overrun is sticky while enabled
  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && rx_en) |=> overrun);

  // R6: sync_det changes only after a bit cycle
  p_sync_bit_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !bit_en) |=> $stable(sync_det));

  // R7: active never rises without a delivered character
  p_active_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_active) |-> out_valid);
endmodule

bind sync_char_rx rxb_checker #(.CHAR_W(CHAR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_en     (rx_en),
  .bit_en    (bit_en),
  .out_data  (out_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .rx_active (rx_active),
  .sync_det  (sync_det),
  .overrun   (overrun)
);

// File: tb/tb_sync_char_rx.sv
module tb_sync_char_rx;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]      sel;
    logic            strip;
    logic [7:0]      sync;
    logic [3:0][7:0] chars;  // chars[0] is sent first
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{2'd3, 1'b1, 8'h16, {8'h3C, 8'hA5, 8'h16, 8'h16}},
    '{2'd3, 1'b0, 8'h16, {8'h16, 8'h41, 8'h16, 8'h16}},
    '{2'd0, 1'b1, 8'h0B, {8'h1F, 8'h0B, 8'h15, 8'h0B}},
    '{2'd1, 1'b0, 8'h2A, {8'h2A, 8'h07, 8'h2A, 8'h11}},
    '{2'd2, 1'b1, 8'h55, {8'h55, 8'h7F, 8'h55, 8'h12}}
  };

  logic clk = 1'b0, rst_n = 1'b0, rx_en = 1'b0, bit_en = 1'b0, rx_bit = 1'b0;
  logic [7:0] sync_pat = 8'h00;
  logic [1:0] len_sel = 2'd3;
  logic strip_sync = 1'b0, out_ready = 1'b0;
  logic [7:0] out_data;
  logic out_valid, rx_active, sync_det, overrun;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_char_rx dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_en(bit_en), .rx_bit(rx_bit),
    .sync_pat(sync_pat), .len_sel(len_sel), .strip_sync(strip_sync),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .rx_active(rx_active), .sync_det(sync_det), .overrun(overrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); rx_bit = b; bit_en = 1'b1;
    @(posedge clk);
    @(negedge clk); bit_en = 1'b0;
  endtask

  task automatic send_char(input logic [7:0] c, input int n);
    for (int i = 0; i < n; i++) send_bit(c[i]);
  endtask

  task automatic take();
    @(negedge clk); out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk); out_ready = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk); rx_en = 1'b0;
    @(posedge clk);
    @(negedge clk); rx_en = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk("R11 valid", out_valid, 0);
    chk("R11 active", rx_active, 0);
    chk("R11 sync_det", sync_det, 0);
    chk("R11 overrun", overrun, 0);
    rst_n = 1'b1;

    // table runs: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < 5; v++) begin
      int n;
      logic [7:0] mask, c, s;
      logic active, second, dlv;
      n = 5 + int'(VECS[v].sel);
      mask = 8'((1 << n) - 1);
      s = VECS[v].sync & mask;
      @(negedge clk); rx_en = 1'b0;
      len_sel = VECS[v].sel; strip_sync = VECS[v].strip; sync_pat = VECS[v].sync;
      restart();
      send_char(s, n);
      chk("R1 lock sync_det", sync_det, 1);
      chk("R4/R5 no delivery of lock sync", out_valid, 0);
      active = 1'b0; second = 1'b0;
      for (int k = 0; k < 4; k++) begin
        c = VECS[v].chars[k] & mask;
        if (strip_sync) dlv = (c != s);
        else if (active) dlv = 1'b1;
        else begin
          dlv = second;
          if (c == s) second = 1'b1;
        end
        if (dlv) active = 1'b1;
        send_char(c, n);
        chk(strip_sync ? "R4 deliver" : "R5 deliver", out_valid, dlv);
        if (dlv) chk("R2 R3 data", out_data, c);
        chk("R6 sync_det at boundary", sync_det, c == s);
        chk("R7 active", rx_active, active);
        if (out_valid) take();
      end
    end

    // R1: fill guard with all-zero pattern
    @(negedge clk); len_sel = 2'd3; strip_sync = 1'b1; sync_pat = 8'h00;
    restart();
    send_char(8'h00, 3);
    chk("R1 no match before N bits", sync_det, 0);
    send_char(8'h00, 5);
    chk("R1 match after N bits", sync_det, 1);

    // R1: search at arbitrary offset
    @(negedge clk); sync_pat = 8'h16;
    restart();
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    send_char(8'h16, 7);
    chk("R1 no early match", sync_det, 0);
    send_bit(1'b0);
    chk("R1 offset match", sync_det, 1);
    repeat (2) @(negedge clk);
    chk("R6 sync_det held between bits", sync_det, 1);
    send_char(8'h5A, 8);
    chk("R6 sync_det drops", sync_det, 0);
    chk("R4 first data", out_data, 8'h5A);
    chk("R7 active rises", rx_active, 1);

    // R9: overrun
    send_char(8'h33, 8);
    chk("R9 overrun set", overrun, 1);
    chk("R9 replaced data", out_data, 8'h33);
    chk("R9 still valid", out_valid, 1);

    // R8: take in same cycle as new delivery
    send_char(8'h44, 7);
    @(negedge clk); rx_bit = 1'b0; bit_en = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk); bit_en = 1'b0; out_ready = 1'b0;
    chk("R8 valid kept on take+push", out_valid, 1);
    chk("R8 new data", out_data, 8'h44);
    chk("R9 overrun sticky", overrun, 1);
    take();
    chk("R8 valid cleared by take", out_valid, 0);

    // R10: disable clears state and alignment
    restart();
    chk("R10 active cleared", rx_active, 0);
    chk("R10 overrun cleared", overrun, 0);
    send_char(8'hA5, 8);
    chk("R10 alignment lost", out_valid, 0);
    chk("R10 still searching", rx_active, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule